// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block decides whether a 64-bit key, received as a stream of bytes, matches one of three stored secrets: one for reading, one for writing and one for configuration. Every verification attempt is first screened by an optional 8-bit attempt counter. That counter is compared against an 8-bit limit. When the two are equal, the block either refuses everything or admits only the configuration secret, depending on a two-bit access code.

Each attempt that is actually checked starts a simulated nonvolatile cycle, modelled as a busy timer. The surrounding protocol engine learns the outcome by polling with the code C0h. The answer is a no-acknowledge while the timer runs, and afterwards it reflects whether the last attempt matched. The stored secrets can be written from the assembled key but are never readable at the ports. The attempt counter is visible and can be loaded, as a configuration access would do.

Top module: `pw_retry_guard`

## Requirements
- R1: The key is formed from the last eight bytes received on `key_byte`. A verify issued before eight bytes have arrived since the previous accepted verify or store fails.
- R2: `store_key` writes the assembled key into the slot picked by `slot_sel` (0 read, 1 write, 2 configuration). All slots reset to all zeros. A key matches only the slot it is checked against.
- R3: A verify while `busy` is low is accepted. One cycle later `result_valid` pulses and `result_pass` shows the outcome. A verify while `busy` is high is ignored, and `result_valid` stays low.
- R4: When an attempt is refused by the lockout, `result_pass` is 0, the counter is unchanged and no busy cycle starts.
- R5: `lock_level` is 0 (open) unless the counter is enabled and equal to `retry_limit`. At that point it is 2 (all refused) when `ua_code` is 2'b10, and 1 (only slot 2 may be verified) for any other code.
- R6: With the counter enabled, a checked attempt that fails increments `retry_cnt` by one, modulo 256, so 255 wraps to 0.
- R7: With the counter enabled, a passing attempt clears `retry_cnt` when `cnt_clr_on_pass` is 1 and leaves it unchanged otherwise.
- R8: With the counter disabled, no limit check is made and `retry_cnt` never changes on an attempt.
- R9: Each checked attempt holds `busy` high for exactly BUSY_TICKS cycles after the accepting edge.
- R10: A `poll` gets its answer one cycle later on `poll_valid` and `poll_ack`. The answer is an acknowledge only when the code is C0h, `busy` is low and the last accepted attempt passed.
- R11: `cnt_wr` loads `cnt_wr_val` into the counter, taking priority over an attempt's update.
- R12: A verify with `slot_sel` equal to 3 is refused in the same way as a lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_byte_valid | input | 1 | Key byte strobe |
| key_byte | input | BYTE_W | Key byte, most significant first |
| slot_sel | input | 2 | Secret slot for store or verify |
| store_key | input | 1 | Write assembled key into slot |
| verify | input | 1 | Verify assembled key against slot |
| cnt_en | input | 1 | Attempt counter enable |
| cnt_clr_on_pass | input | 1 | Clear counter after a pass |
| ua_code | input | 2 | Lockout severity code |
| retry_limit | input | CNT_W | Attempt limit |
| cnt_wr | input | 1 | Load attempt counter |
| cnt_wr_val | input | CNT_W | Counter load value |
| poll | input | 1 | Acknowledge poll strobe |
| poll_code | input | 8 | Poll command code |
| result_valid | output | 1 | Pulse one cycle after an accepted verify |
| result_pass | output | 1 | Outcome of last accepted verify |
| poll_valid | output | 1 | Poll answer valid |
| poll_ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| busy | output | 1 | Simulated nonvolatile cycle in progress |
| retry_cnt | output | CNT_W | Attempt counter |
| lock_level | output | 2 | 0 open, 1 configuration only, 2 all refused |

## Verification
Several rules are checked on every cycle by the assertions. A refused attempt leaves the counter and timer untouched. A checked failure steps the counter by one, and a checked pass with clearing enabled zeroes it. A disabled counter holds, every checked attempt raises `busy`, and a poll during `busy` is never acknowledged. Some behaviour can only be shown by the bench scenarios. These cover which slot a stored key lands in, that the last eight bytes form the key, the exact length of the busy window, the wrap from 255, and the acknowledge that follows a passing attempt once the timer expires.

// File: rtl/pwv_pkg.sv
package pwv_pkg;

    localparam int BYTE_W_DEF   = 8;
    localparam int PW_BYTES_DEF = 8;
    localparam int CNT_W_DEF    = 8;
    localparam int NUM_SLOTS    = 3;
    localparam int SEL_W        = 2;

    localparam logic [7:0] POLL_CODE = 8'hC0;
    localparam logic [1:0] UA_ALL    = 2'b10;

    typedef enum logic [1:0] {
        SEL_READ  = 2'd0,
        SEL_WRITE = 2'd1,
        SEL_CFG   = 2'd2,
        SEL_NONE  = 2'd3
    } pw_sel_e;

    typedef enum logic [1:0] {
        LOCK_OPEN     = 2'd0,
        LOCK_CFG_ONLY = 2'd1,
        LOCK_ALL      = 2'd2
    } lock_e;

    function automatic lock_e lock_of(input logic at_limit, input logic [1:0] ua);
        if (!at_limit)       return LOCK_OPEN;
        else if (ua == UA_ALL) return LOCK_ALL;
        else                 return LOCK_CFG_ONLY;
    endfunction

    function automatic logic attempt_allowed(input lock_e lvl, input pw_sel_e sel);
        if (sel == SEL_NONE) return 1'b0;
        case (lvl)
            LOCK_OPEN:     return 1'b1;
            LOCK_CFG_ONLY: return sel == SEL_CFG;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwv_key_shift.sv
module pwv_key_shift #(
    parameter int BYTE_W   = 8,
    parameter int PW_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         byte_valid,
    input  logic [BYTE_W-1:0]            byte_in,
    input  logic                         clear,
    output logic [BYTE_W*PW_BYTES-1:0]   key,
    output logic                         full
);
    localparam int KEY_W = BYTE_W * PW_BYTES;
    localparam int CW    = $clog2(PW_BYTES + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(PW_BYTES);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            key   <= '0;
            count <= '0;
        end else begin
            if (byte_valid)
                key <= {key[KEY_W-BYTE_W-1:0], byte_in};
            if (clear)
                count <= '0;
            else if (byte_valid && count != FULL_CNT)
                count <= count + 1'b1;
        end
    end

    assign full = (count == FULL_CNT);
endmodule

// File: rtl/pwv_pw_store.sv
module pwv_pw_store #(
    parameter int KEY_W     = 64,
    parameter int NUM_SLOTS = 3,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [KEY_W-1:0] key,
    output logic             match
);
    logic [NUM_SLOTS-1:0] hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [KEY_W-1:0] secret;
        always_ff @(posedge clk) begin
            if (rst)
                secret <= '0;
            else if (wr && sel == SEL_W'(g))
                secret <= key;
        end
        assign hit[g] = (sel == SEL_W'(g)) && (secret == key);
    end

    assign match = |hit;
endmodule

// File: rtl/pwv_retry.sv
module pwv_retry
    import pwv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             clr_on_pass,
    input  logic [CNT_W-1:0] limit,
    input  logic [1:0]       ua_code,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             upd,
    input  logic             upd_pass,
    output logic [CNT_W-1:0] count,
    output lock_e            level
);
    logic at_limit;

    assign at_limit = cnt_en && (count == limit);
    assign level    = lock_of(at_limit, ua_code);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (upd && cnt_en) begin
            if (!upd_pass)
                count <= count + 1'b1;
            else if (clr_on_pass)
                count <= '0;
        end
    end
endmodule

// File: rtl/pwv_busy.sv
module pwv_busy #(
    parameter int TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= TW'(TICKS);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/pw_retry_guard.sv
module pw_retry_guard
    import pwv_pkg::*;
#(
    parameter int BYTE_W     = BYTE_W_DEF,
    parameter int PW_BYTES   = PW_BYTES_DEF,
    parameter int CNT_W      = CNT_W_DEF,
    parameter int BUSY_TICKS = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_byte_valid,
    input  logic [BYTE_W-1:0] key_byte,
    input  logic [1:0]        slot_sel,
    input  logic              store_key,
    input  logic              verify,
    input  logic              cnt_en,
    input  logic              cnt_clr_on_pass,
    input  logic [1:0]        ua_code,
    input  logic [CNT_W-1:0]  retry_limit,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wr_val,
    input  logic              poll,
    input  logic [7:0]        poll_code,
    output logic              result_valid,
    output logic              result_pass,
    output logic              poll_valid,
    output logic              poll_ack,
    output logic              busy,
    output logic [CNT_W-1:0]  retry_cnt,
    output logic [1:0]        lock_level
);
    localparam int KEY_W = BYTE_W * PW_BYTES;

    logic [KEY_W-1:0] key;
    logic             key_full;
    logic             match;
    lock_e            level;
    logic             accept;
    logic             checked;
    logic             good;
    logic             pass_q;

    assign accept  = verify && !busy;
    assign checked = accept && attempt_allowed(level, pw_sel_e'(slot_sel));
    assign good    = checked && match && key_full;

    pwv_key_shift #(.BYTE_W(BYTE_W), .PW_BYTES(PW_BYTES)) u_shift (
        .clk(clk), .rst(rst),
        .byte_valid(key_byte_valid), .byte_in(key_byte),
        .clear(accept || store_key),
        .key(key), .full(key_full)
    );

    pwv_pw_store #(.KEY_W(KEY_W), .NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_store (
        .clk(clk), .rst(rst),
        .wr(store_key), .sel(slot_sel), .key(key),
        .match(match)
    );

    pwv_retry #(.CNT_W(CNT_W)) u_retry (
        .clk(clk), .rst(rst),
        .cnt_en(cnt_en), .clr_on_pass(cnt_clr_on_pass),
        .limit(retry_limit), .ua_code(ua_code),
        .load(cnt_wr), .load_val(cnt_wr_val),
        .upd(checked), .upd_pass(good),
        .count(retry_cnt), .level(level)
    );

    pwv_busy #(.TICKS(BUSY_TICKS)) u_busy (
        .clk(clk), .rst(rst), .start(checked), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            pass_q       <= 1'b0;
            poll_valid   <= 1'b0;
            poll_ack     <= 1'b0;
        end else begin
            result_valid <= accept;
            if (accept)
                pass_q <= good;
            poll_valid <= poll;
            poll_ack   <= poll && (poll_code == POLL_CODE) && !busy && pass_q;
        end
    end

    assign result_pass = pass_q;
    assign lock_level  = level;
endmodule

// File: rtl/pwv_checker.sv
module pwv_checker
    import pwv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             verify,
    input logic             busy,
    input logic             checked,
    input logic             good,
    input logic             cnt_en,
    input logic             cnt_clr_on_pass,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] retry_cnt,
    input logic [1:0]       lock_level,
    input logic             poll,
    input logic             poll_valid,
    input logic             poll_ack,
    input logic             result_valid,
    input logic             result_pass
);
    p_refuse_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (verify && !busy && !checked && !cnt_wr)
        |=> (result_valid && !result_pass && !busy && $stable(retry_cnt)));

    p_level_legal_r5: assert property (@(posedge clk) disable iff (rst)
        lock_level != 2'b11);

    p_fail_steps_r6: assert property (@(posedge clk) disable iff (rst)
        (checked && !good && cnt_en && !cnt_wr)
        |=> retry_cnt == $past(retry_cnt) + CNT_W'(1));

    p_pass_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (good && cnt_en && cnt_clr_on_pass && !cnt_wr) |=> retry_cnt == '0);

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cnt_wr) |=> $stable(retry_cnt));

    p_busy_starts_r9: assert property (@(posedge clk) disable iff (rst)
        checked |=> busy);

    p_busy_nack_r10: assert property (@(posedge clk) disable iff (rst)
        (poll && busy) |=> (poll_valid && !poll_ack));
endmodule

bind pw_retry_guard pwv_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .verify(verify), .busy(busy),
    .checked(checked), .good(good),
    .cnt_en(cnt_en), .cnt_clr_on_pass(cnt_clr_on_pass), .cnt_wr(cnt_wr),
    .retry_cnt(retry_cnt), .lock_level(lock_level),
    .poll(poll), .poll_valid(poll_valid), .poll_ack(poll_ack),
    .result_valid(result_valid), .result_pass(result_pass)
);

// File: tb/tb_pw_retry_guard.sv
module tb_pw_retry_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_byte_valid = 1'b0;
    logic [7:0]  key_byte = '0;
    logic [1:0]  slot_sel = '0;
    logic        store_key = 1'b0;
    logic        verify = 1'b0;
    logic        cnt_en = 1'b0;
    logic        cnt_clr_on_pass = 1'b0;
    logic [1:0]  ua_code = '0;
    logic [7:0]  retry_limit = '0;
    logic        cnt_wr = 1'b0;
    logic [7:0]  cnt_wr_val = '0;
    logic        poll = 1'b0;
    logic [7:0]  poll_code = '0;
    logic        result_valid, result_pass, poll_valid, poll_ack, busy;
    logic [7:0]  retry_cnt;
    logic [1:0]  lock_level;

    int tests = 0;
    int fails = 0;

    localparam logic [63:0] K1 = 64'h1122_3344_5566_7788;
    localparam logic [63:0] K2 = 64'h1122_3344_5566_7789;
    localparam logic [63:0] K3 = 64'hC0FF_EE00_DEAD_BEEF;

    always #(CLK_PERIOD/2) clk = ~clk;

    pw_retry_guard #(.BUSY_TICKS(TICKS)) dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bytes(input logic [63:0] k, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            key_byte_valid = 1'b1;
            key_byte = k[63-8*(i%8) -: 8];
        end
        @(negedge clk);
        key_byte_valid = 1'b0;
    endtask

    task automatic store(input logic [1:0] s, input logic [63:0] k);
        send_bytes(k, 8);
        @(negedge clk); store_key = 1'b1; slot_sel = s;
        @(negedge clk); store_key = 1'b0;
    endtask

    task automatic pulse_verify(input logic [1:0] s);
        @(negedge clk); verify = 1'b1; slot_sel = s;
        @(negedge clk); verify = 1'b0;
    endtask

    task automatic try_key(input logic [1:0] s, input logic [63:0] k);
        send_bytes(k, 8);
        pulse_verify(s);
    endtask

    task automatic load_cnt(input logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wr_val = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic do_poll(input logic [7:0] code);
        @(negedge clk); poll = 1'b1; poll_code = code;
        @(negedge clk); poll = 1'b0;
    endtask

    task automatic wait_idle;
        repeat (TICKS + 2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R3 reset result_valid", result_valid, 0);
        chk("R3 reset result_pass", result_pass, 0);
        chk("R9 reset busy", busy, 0);
        chk("R11 reset retry_cnt", retry_cnt, 0);
        chk("R5 reset lock_level", lock_level, 0);
        chk("R10 reset poll_ack", poll_ack, 0);
    endtask

    task automatic t_default_secret;
        try_key(2'd0, 64'h0);
        chk("R2 zero secret valid", result_valid, 1);
        chk("R2 zero secret pass", result_pass, 1);
        chk("R9 busy after check", busy, 1);
        do_poll(8'hC0);
        chk("R10 poll while busy valid", poll_valid, 1);
        chk("R10 poll while busy nack", poll_ack, 0);
        repeat (TICKS - 3) @(negedge clk);
        chk("R9 busy at last tick", busy, 1);
        @(negedge clk);
        chk("R9 busy ends", busy, 0);
        do_poll(8'hC0);
        chk("R10 ack after pass", poll_ack, 1);
        do_poll(8'hA5);
        chk("R10 other code nack", poll_ack, 0);
    endtask

    task automatic t_store_match;
        store(2'd1, K1);
        try_key(2'd1, K1);
        chk("R2 stored key pass", result_pass, 1);
        wait_idle();
        try_key(2'd1, K2);
        chk("R2 wrong key fail", result_pass, 0);
        wait_idle();
        do_poll(8'hC0);
        chk("R10 nack after fail", poll_ack, 0);
        try_key(2'd0, K1);
        chk("R2 slot separation", result_pass, 0);
        wait_idle();
    endtask

    task automatic t_busy_ignore;
        try_key(2'd1, K1);
        send_bytes(K1, 8);
        pulse_verify(2'd1);
        chk("R3 verify ignored while busy", result_valid, 0);
        wait_idle();
    endtask

    task automatic t_key_length;
        send_bytes(64'h0, 3);
        pulse_verify(2'd0);
        chk("R1 short key fails", result_pass, 0);
        wait_idle();
        send_bytes(64'hAAAA_0000_0000_0000, 2);
        send_bytes(K1, 8);
        pulse_verify(2'd1);
        chk("R1 last eight bytes pass", result_pass, 1);
        wait_idle();
    endtask

    task automatic t_retry;
        cnt_en = 1'b1; cnt_clr_on_pass = 1'b1; retry_limit = 8'd5;
        load_cnt(8'd0);
        chk("R11 counter load", retry_cnt, 0);
        try_key(2'd1, K2); wait_idle();
        try_key(2'd1, K2);
        chk("R6 two failures", retry_cnt, 2);
        wait_idle();
        try_key(2'd1, K1);
        chk("R7 pass clears", retry_cnt, 0);
        wait_idle();
        cnt_clr_on_pass = 1'b0;
        try_key(2'd1, K2); wait_idle();
        try_key(2'd1, K1);
        chk("R7 pass keeps count", retry_cnt, 1);
        wait_idle();
        cnt_en = 1'b0;
        try_key(2'd1, K2);
        chk("R8 disabled holds", retry_cnt, 1);
        wait_idle();
    endtask

    task automatic t_lock;
        store(2'd2, K3);
        cnt_en = 1'b1; cnt_clr_on_pass = 1'b1; retry_limit = 8'd2; ua_code = 2'b10;
        load_cnt(8'd2);
        chk("R5 level all", lock_level, 2);
        try_key(2'd1, K1);
        chk("R4 refused pass", result_pass, 0);
        chk("R4 refused valid", result_valid, 1);
        chk("R4 refused no busy", busy, 0);
        chk("R4 refused count", retry_cnt, 2);
        try_key(2'd2, K3);
        chk("R5 cfg refused at all-level", result_pass, 0);
        ua_code = 2'b00;
        @(negedge clk);
        chk("R5 level cfg only", lock_level, 1);
        try_key(2'd1, K1);
        chk("R5 non-cfg refused", result_pass, 0);
        try_key(2'd2, K3);
        chk("R5 cfg allowed pass", result_pass, 1);
        chk("R7 cfg pass clears", retry_cnt, 0);
        chk("R5 level reopens", lock_level, 0);
        wait_idle();
    endtask

    task automatic t_wrap;
        retry_limit = 8'd10;
        load_cnt(8'd255);
        try_key(2'd1, K2);
        chk("R6 wrap to zero", retry_cnt, 0);
        wait_idle();
    endtask

    task automatic t_bad_sel;
        load_cnt(8'd4);
        try_key(2'd3, K1);
        chk("R12 slot3 fails", result_pass, 0);
        chk("R12 slot3 no busy", busy, 0);
        chk("R12 slot3 count", retry_cnt, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_secret();
        t_store_match();
        t_busy_ignore();
        t_key_length();
        t_retry();
        t_lock();
        t_wrap();
        t_bad_sel();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule